// File: doc/BRIEF.md
# Configurable Watchdog and Reset Generator

This block is the reset and watchdog section of a small microcontroller. One counter chain serves two purposes. After power-on it times a fixed power-up delay before the chip leaves reset. After that it acts as a watchdog: software must clear it periodically, and if it does not, a timeout forces an internal reset.

A five-bit mode register controls the watchdog. Its fields are:
- a timeout tap select;
- separate enables that decide whether counting continues during HALT and during STOP;
- a choice between two count clocks, an internal RC oscillator tick and the crystal clock.

The crystal clock is absent in STOP, so the chain freezes in STOP when the crystal source is selected. An external reset pin passes through a sample filter before it is accepted. Every reset source holds the internal reset output high for a fixed stretch of system clocks.

Both oscillators appear at the block's edge as clock enables sampled on the system clock. The RC timing is expressed as a parameter that gives the number of RC ticks per millisecond.

Top module: `wdt_reset_gen`

## Requirements
- R1: While `porN` is low, and immediately after it rises, `rstOut` is high. The mode register resets to its default: tap code 01, HALT run 1, STOP run 1, RC source. With the default mode, a timeout occurs after 15 ms of RC ticks, counted from the end of the reset stretch.
- R2: After power-on, `rstOut` stays high until 5 ms of RC ticks (5 × TICKS_PER_MS) have been counted. It then stays high for a further STRETCH_LEN clocks.
- R3: With `modeWdata[4]`=0, the tap code in `modeWdata[1:0]` (00, 01, 10, 11) selects a timeout of 5, 15, 25 or 100 ms of RC ticks. The internal reset rises on the clock after the final tick, and the count never reaches the selected limit.
- R4: With `modeWdata[4]`=1, tap codes 00, 01, 10 and 11 select timeouts of 256, 512, 1024 and 4096 `xtalTick` cycles.
- R5: A `wdtClear` pulse sets the count to zero. A clear in the same cycle as the final tick prevents that timeout.
- R6: A write to the mode register sets the count to zero.
- R7: When `haltMode` is high and `modeWdata[2]`=0, the count freezes. When `modeWdata[2]`=1, counting continues during HALT.
- R8: When `stopMode` is high, the count freezes if `modeWdata[3]`=0, and it always freezes when the crystal source is selected. With the RC source and `modeWdata[3]`=1, counting continues.
- R9: `extResetN` is accepted only after FILTER_LEN consecutive samples at the new level, so a 3-sample low pulse is ignored. The internal reset stays high while the filtered pin is low.
- R10: A watchdog timeout, or the release of the filtered pin, holds `rstOut` high for exactly STRETCH_LEN (18) clocks. During the reset the mode register returns to its default and the count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rcTick | input | 1 | RC oscillator tick enable |
| xtalTick | input | 1 | Crystal clock tick enable |
| wdtClear | input | 1 | Watchdog clear strobe |
| modeWe | input | 1 | Mode register write enable |
| modeWdata | input | 5 | Mode value: [4] source, [3] STOP run, [2] HALT run, [1:0] tap |
| extResetN | input | 1 | External reset pin, active low |
| haltMode | input | 1 | CPU is in HALT |
| stopMode | input | 1 | CPU is in STOP |
| rstOut | output | 1 | Internal reset, active high |

## Verification
All eight combinations of tap code and clock source are swept. Each timeout is measured in edges from the mode write, which separates the four taps and also shows whether the crystal table or the RC table was applied.

The freeze tests place a long HALT or STOP interval in the middle of a count. The length of the remaining count then shows whether the chain held its value, kept running, or was cleared.

Clear and rewrite tests are timed against the final tick. A 3-sample pin glitch is contrasted with a sustained low to check the filter boundary.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic       srcXtal;
    logic       stopRun;
    logic       haltRun;
    logic [1:0] tap;
  } wdtModeT;

  localparam wdtModeT MODE_DEFAULT = '{srcXtal: 1'b0, stopRun: 1'b1, haltRun: 1'b1, tap: 2'b01};

  typedef struct packed {
    logic clr;
    logic inc;
  } wdtStrobeT;

  function automatic int tapLimit(input logic xtal, input logic [1:0] tap, input int tpm);
    int lim;
    if (xtal) begin
      case (tap)
        2'd0: lim = 256;
        2'd1: lim = 512;
        2'd2: lim = 1024;
        default: lim = 4096;
      endcase
    end else begin
      case (tap)
        2'd0: lim = 5 * tpm;
        2'd1: lim = 15 * tpm;
        2'd2: lim = 25 * tpm;
        default: lim = 100 * tpm;
      endcase
    end
    return lim;
  endfunction

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             porN,
  input  wdtStrobeT        strobe,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  logic atLast;

  assign atLast = (count == limit - CNT_W'(1));
  assign hit    = strobe.inc && !strobe.clr && atLast;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      count <= '0;
    end else if (strobe.clr) begin
      count <= '0;
    end else if (strobe.inc) begin
      count <= atLast ? '0 : count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_MS = 4,
  parameter int POR_MS       = 5,
  parameter int STRETCH_LEN  = 18,
  parameter int FILTER_LEN   = 4,
  parameter int CNT_W        = 13
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rcTick,
  input  logic             xtalTick,
  input  logic             wdtClear,
  input  logic             modeWe,
  input  logic [4:0]       modeWdata,
  input  logic             extResetN,
  input  logic             haltMode,
  input  logic             stopMode,
  input  logic             hit,
  output wdtStrobeT        strobe,
  output logic [CNT_W-1:0] limit,
  output wdtModeT          modeQ,
  output logic             rstOut
);

  localparam int SW = $clog2(STRETCH_LEN + 1);
  localparam int FW = $clog2(FILTER_LEN + 1);

  logic          porPhase;
  logic [SW-1:0] stretchCnt;
  logic [FW-1:0] fltCnt;
  logic          pinFilt;
  logic          rstActive;
  logic          freeze;
  logic          tick;

  assign rstActive = porPhase || (stretchCnt != '0);
  assign rstOut    = rstActive;

  // Mode register: default while any reset is active.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)          modeQ <= MODE_DEFAULT;
    else if (rstActive) modeQ <= MODE_DEFAULT;
    else if (modeWe)    modeQ <= wdtModeT'(modeWdata);
  end

  // Pin filter: a new level must be seen on FILTER_LEN consecutive samples.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pinFilt <= 1'b1;
      fltCnt  <= '0;
    end else if (extResetN == pinFilt) begin
      fltCnt <= '0;
    end else if (fltCnt == FW'(FILTER_LEN - 1)) begin
      pinFilt <= extResetN;
      fltCnt  <= '0;
    end else begin
      fltCnt <= fltCnt + FW'(1);
    end
  end

  // Power-up phase and reset stretch.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      porPhase   <= 1'b1;
      stretchCnt <= '0;
    end else begin
      if (porPhase && hit) porPhase <= 1'b0;
      if (hit || !pinFilt)          stretchCnt <= SW'(STRETCH_LEN);
      else if (stretchCnt != '0)    stretchCnt <= stretchCnt - SW'(1);
    end
  end

  assign tick   = modeQ.srcXtal ? xtalTick : rcTick;
  assign freeze = (haltMode && !modeQ.haltRun) ||
                  (stopMode && (!modeQ.stopRun || modeQ.srcXtal));

  always_comb begin
    if (porPhase) begin
      strobe.clr = 1'b0;
      strobe.inc = rcTick;
      limit      = CNT_W'(POR_MS * TICKS_PER_MS);
    end else begin
      strobe.clr = rstActive || wdtClear || modeWe;
      strobe.inc = !rstActive && !freeze && tick;
      limit      = CNT_W'(tapLimit(modeQ.srcXtal, modeQ.tap, TICKS_PER_MS));
    end
  end

endmodule

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_MS = 4,
  parameter int POR_MS       = 5,
  parameter int STRETCH_LEN  = 18,
  parameter int FILTER_LEN   = 4
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rcTick,
  input  logic       xtalTick,
  input  logic       wdtClear,
  input  logic       modeWe,
  input  logic [4:0] modeWdata,
  input  logic       extResetN,
  input  logic       haltMode,
  input  logic       stopMode,
  output logic       rstOut
);

  localparam int RC_MAX   = 100 * TICKS_PER_MS;
  localparam int MAX_LIM0 = (RC_MAX > 4096) ? RC_MAX : 4096;
  localparam int MAX_LIM  = (POR_MS * TICKS_PER_MS > MAX_LIM0) ? POR_MS * TICKS_PER_MS : MAX_LIM0;
  localparam int CNT_W    = $clog2(MAX_LIM + 1);

  wdtStrobeT        strobe;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;
  logic             hit;
  wdtModeT          modeQ;

  wdt_ctrl #(
    .TICKS_PER_MS(TICKS_PER_MS), .POR_MS(POR_MS), .STRETCH_LEN(STRETCH_LEN),
    .FILTER_LEN(FILTER_LEN), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .porN(porN), .rcTick(rcTick), .xtalTick(xtalTick),
    .wdtClear(wdtClear), .modeWe(modeWe), .modeWdata(modeWdata),
    .extResetN(extResetN), .haltMode(haltMode), .stopMode(stopMode),
    .hit(hit), .strobe(strobe), .limit(limit), .modeQ(modeQ), .rstOut(rstOut)
  );

  wdt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .porN(porN), .strobe(strobe), .limit(limit),
    .count(count), .hit(hit)
  );

endmodule

// File: rtl/wdt_reset_gen_chk.sv
module wdt_reset_gen_chk
  import wdt_pkg::*;
#(
  parameter int STRETCH_LEN = 18,
  parameter int CNT_W       = 13
) (
  input logic             clk,
  input logic             porN,
  input logic             wdtClear,
  input logic             modeWe,
  input logic             haltMode,
  input logic             stopMode,
  input logic             rstOut,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] limit,
  input wdtModeT          modeQ
);

  logic [15:0] runLen;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                runLen <= '0;
    else if (!rstOut)         runLen <= '0;
    else if (runLen != '1)    runLen <= runLen + 16'd1;
  end

  p_count_in_range_r3: assert property (@(posedge clk) disable iff (!porN)
    count < limit);

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!porN)
    (wdtClear && !rstOut) |=> (count == '0));

  p_write_zero_r6: assert property (@(posedge clk) disable iff (!porN)
    (modeWe && !rstOut) |=> (count == '0));

  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!porN)
    (haltMode && !modeQ.haltRun && !rstOut && !wdtClear && !modeWe) |=> $stable(count));

  p_stop_xtal_freeze_r8: assert property (@(posedge clk) disable iff (!porN)
    (stopMode && modeQ.srcXtal && !rstOut && !wdtClear && !modeWe) |=> $stable(count));

  p_stretch_len_r10: assert property (@(posedge clk) disable iff (!porN)
    $fell(rstOut) |-> (runLen >= 16'(STRETCH_LEN)));

endmodule

bind wdt_reset_gen wdt_reset_gen_chk #(.STRETCH_LEN(STRETCH_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .porN(porN), .wdtClear(wdtClear), .modeWe(modeWe),
  .haltMode(haltMode), .stopMode(stopMode), .rstOut(rstOut),
  .count(count), .limit(limit), .modeQ(modeQ)
);

// File: tb/sim_wdt_reset_gen.sv
module sim_wdt_reset_gen;

  localparam int TPM     = 2;
  localparam int STRETCH = 18;

  logic       clk = 1'b0;
  logic       porN, rcTick, xtalTick, wdtClear, modeWe, extResetN, haltMode, stopMode;
  logic [4:0] modeWdata;
  logic       rstOut;
  int         nChecks = 0;
  int         nFails  = 0;
  logic       sawRst;

  always #4 clk = ~clk;

  wdt_reset_gen #(.TICKS_PER_MS(TPM)) u0 (
    .clk(clk), .porN(porN), .rcTick(rcTick), .xtalTick(xtalTick),
    .wdtClear(wdtClear), .modeWe(modeWe), .modeWdata(modeWdata),
    .extResetN(extResetN), .haltMode(haltMode), .stopMode(stopMode),
    .rstOut(rstOut)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); @(negedge clk);
      modeWe = 1'b0; wdtClear = 1'b0;
      if (rstOut) sawRst = 1'b1;
    end
  endtask

  task automatic measureRise(output int n, input int cap);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      modeWe = 1'b0; wdtClear = 1'b0;
      n++;
    end while (!rstOut && n < cap);
  endtask

  task automatic measureStretch(output int hi);
    hi = 1;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); @(negedge clk);
      if (rstOut) hi++;
      else break;
    end
  endtask

  task automatic writeMode(input logic [4:0] m);
    modeWdata = m; modeWe = 1'b1;
  endtask

  function automatic int expLimit(input int src, input int code);
    if (src != 0) return (code == 3) ? 4096 : (256 << code);
    case (code)
      0: return 5 * TPM;
      1: return 15 * TPM;
      2: return 25 * TPM;
      default: return 100 * TPM;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    int n;
    int hi;
    porN = 1'b0; rcTick = 1'b1; xtalTick = 1'b1; wdtClear = 1'b0; modeWe = 1'b0;
    modeWdata = '0; extResetN = 1'b1; haltMode = 1'b0; stopMode = 1'b0; sawRst = 1'b0;
    repeat (3) @(negedge clk);
    check(rstOut == 1'b1, "R1 reset held during power-on", int'(rstOut), 1);
    porN = 1'b1;
    @(negedge clk);
    check(rstOut == 1'b1, "R1 reset after power-on release", int'(rstOut), 1);

    // R2: power-up delay plus stretch, counted in edges since release.
    n = 1;
    while (rstOut && n < 500) begin
      @(posedge clk); @(negedge clk); n++;
    end
    check(n == 5 * TPM + STRETCH, "R2 power-up release edge", n, 5 * TPM + STRETCH);

    // R1: default mode gives 15 ms of RC ticks.
    measureRise(n, 1000);
    check(n == 15 * TPM, "R1 default timeout", n, 15 * TPM);
    measureStretch(hi);
    check(hi == STRETCH, "R10 stretch after timeout", hi, STRETCH);

    // R3, R4: sweep every tap under both sources.
    for (int src = 0; src < 2; src++) begin
      for (int code = 0; code < 4; code++) begin
        int lim;
        lim = expLimit(src, code);
        writeMode({src[0], 1'b1, 1'b1, code[1:0]});
        measureRise(n, lim + 60);
        check(n == lim + 1, (src != 0) ? "R4 crystal tap" : "R3 RC tap", n, lim + 1);
        measureStretch(hi);
        check(hi == STRETCH, "R10 stretch per tap", hi, STRETCH);
      end
    end

    // R5: clear on the final tick defers the timeout.
    writeMode(5'b01100);
    step(10);
    check(rstOut == 1'b0, "R5 no timeout before final tick", int'(rstOut), 0);
    wdtClear = 1'b1;
    measureRise(n, 100);
    check(n == 5 * TPM + 1, "R5 clear on final tick", n, 5 * TPM + 1);
    measureStretch(hi);

    // R5: periodic clears keep the reset away.
    writeMode(5'b01100);
    step(1);
    sawRst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step(5);
      wdtClear = 1'b1;
    end
    step(1);
    check(sawRst == 1'b0, "R5 periodic clear", int'(sawRst), 0);

    // R6: mode write restarts the count.
    writeMode(5'b01100);
    step(8);
    writeMode(5'b01100);
    measureRise(n, 100);
    check(n == 5 * TPM + 1, "R6 write clears count", n, 5 * TPM + 1);
    measureStretch(hi);

    // R7: HALT freezes when its run bit is 0.
    writeMode(5'b01000);
    step(5);
    haltMode = 1'b1; sawRst = 1'b0;
    step(50);
    check(sawRst == 1'b0, "R7 HALT frozen", int'(sawRst), 0);
    haltMode = 1'b0;
    measureRise(n, 100);
    check(n == 5 * TPM - 4, "R7 HALT count held", n, 5 * TPM - 4);
    measureStretch(hi);

    writeMode(5'b01100);
    haltMode = 1'b1;
    measureRise(n, 100);
    check(n == 5 * TPM + 1, "R7 HALT run enabled", n, 5 * TPM + 1);
    haltMode = 1'b0;
    measureStretch(hi);

    // R8: STOP with run bit 0 on RC source.
    writeMode(5'b00100);
    step(5);
    stopMode = 1'b1; sawRst = 1'b0;
    step(50);
    check(sawRst == 1'b0, "R8 STOP frozen RC", int'(sawRst), 0);
    stopMode = 1'b0;
    measureRise(n, 100);
    check(n == 5 * TPM - 4, "R8 STOP count held RC", n, 5 * TPM - 4);
    measureStretch(hi);

    // R8: crystal source freezes in STOP even with the run bit set.
    writeMode(5'b11100);
    step(101);
    stopMode = 1'b1; sawRst = 1'b0;
    step(300);
    check(sawRst == 1'b0, "R8 STOP frozen crystal", int'(sawRst), 0);
    stopMode = 1'b0;
    measureRise(n, 400);
    check(n == 156, "R8 STOP count held crystal", n, 156);
    measureStretch(hi);

    writeMode(5'b01100);
    stopMode = 1'b1;
    measureRise(n, 100);
    check(n == 5 * TPM + 1, "R8 STOP run RC", n, 5 * TPM + 1);
    stopMode = 1'b0;
    measureStretch(hi);

    // R9: pin filter.
    rcTick = 1'b0;
    extResetN = 1'b0;
    step(3);
    extResetN = 1'b1; sawRst = 1'b0;
    step(10);
    check(sawRst == 1'b0, "R9 3-sample glitch ignored", int'(sawRst), 0);
    extResetN = 1'b0;
    measureRise(n, 50);
    check(n == 5, "R9 pin accepted after 4 samples", n, 5);
    sawRst = 1'b1;
    step(40);
    check(rstOut == 1'b1, "R9 reset held while pin low", int'(rstOut), 1);
    extResetN = 1'b1;
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (rstOut && n < 100);
    check(n == FILTER_EDGES + STRETCH, "R10 stretch after pin release", n, FILTER_EDGES + STRETCH);
    rcTick = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  localparam int FILTER_EDGES = 4;

endmodule